// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

A target device on an I2C bus can be left holding SDA low when the host is reset in the middle of a transfer. No controller can then issue a START, so the bus stays dead. This block sits between the normal I2C controller and the open-drain pad drivers and frees such a bus. It runs once on its own after reset, and it runs again whenever a start strobe arrives while it is idle. It takes pin ownership away from the controller through a mux and releases both lines. After a setup wait it looks at SDA. If SDA is low it clocks SCL a fixed number of times so the target can finish shifting out its byte and let go. Then it returns the pins to the controller.

Both lines are open-drain. The block only asserts an output-enable, which pulls the line low, or deasserts it, which lets the pull-up raise the line. It never drives SDA low. All phase lengths are whole microseconds, counted from a shared tick that a clocks-per-microsecond parameter sets up. The raw line inputs pass through a two-flop synchronizer before any decision uses them.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is held, and after it until the first sequence starts, busy_o and done_o are 0 and the pins follow the controller: scl_oe_o equals ctrl_scl_oe_i and sda_oe_o equals ctrl_sda_oe_i, with ctrl_own_o at 1.
- R2: After reset is released the sequence starts by itself exactly once, with no start strobe.
- R3: A sequence opens with a setup phase that lasts SETUP_US microseconds (SETUP_US*CLK_PER_US clocks), with both output-enables at 0. At its end the synchronized SDA is sampled. If SDA is high the sequence ends there, with no SCL pulse, so busy_o is high for exactly SETUP_US*CLK_PER_US clocks.
- R4: If SDA sampled low, scl_oe_o goes high exactly PULSE_COUNT times. Each pulse holds scl_oe_o at 1 (SCL low) for HALF_US*CLK_PER_US clocks, then at 0 for the same time, low phase first. busy_o is then high for (SETUP_US + 2*PULSE_COUNT*HALF_US)*CLK_PER_US clocks.
- R5: While the block owns the pins, sda_oe_o stays 0.
- R6: While busy_o is 1, ctrl_own_o is 0 and ctrl_scl_oe_i and ctrl_sda_oe_i have no effect on scl_oe_o or sda_oe_o. Once busy_o falls, the pins follow the controller again.
- R7: busy_o rises on the clock edge that accepts a start and stays high until the cycle in which done_o is 1. done_o is 1 for exactly one cycle, and busy_o is 0 in that cycle.
- R8: A start strobe that arrives while busy_o is 1 is ignored. The sequence length is unchanged and only one done_o pulse follows.
- R9: pulsed_o is 1 after a sequence that issued pulses and 0 after one that skipped them. It holds its value until the next sequence starts.
- R10: still_low_o is 1 when the synchronized SDA is still low at the end of the last released-high phase, and 0 otherwise. It holds until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one clock wide |
| scl_in_i | input | 1 | Raw SCL line level from the pad |
| sda_in_i | input | 1 | Raw SDA line level from the pad |
| ctrl_scl_oe_i | input | 1 | SCL pull-low request from the normal controller |
| ctrl_sda_oe_i | input | 1 | SDA pull-low request from the normal controller |
| scl_oe_o | output | 1 | SCL pad output-enable (1 pulls low) |
| sda_oe_o | output | 1 | SDA pad output-enable (1 pulls low) |
| ctrl_own_o | output | 1 | 1 when the normal controller owns the pins |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| pulsed_o | output | 1 | Last sequence issued clock pulses |
| still_low_o | output | 1 | SDA was still low after the last pulse |

## Verification
A wrong phase or microsecond count shows up at once as a busy window of the wrong length, or as SCL low widths other than HALF_US*CLK_PER_US clocks, within one pulse period. A pulse counter that is off by one shows up as the wrong number of low pulses on scl_oe_o. A target that lets go after the last pulse also ends up reported as still stuck, or released one pulse too early. A broken ownership or skip decision leaks the controller's enables onto the pins during a run, or produces pulses on a free bus. The bench sweeps how long a modelled target keeps SDA low, from zero up to past the pulse count, and catches all of these within one sequence.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
    typedef enum logic [1:0] {
        BC_IDLE  = 2'd0,
        BC_SETUP = 2'd1,
        BC_LOW   = 2'd2,
        BC_HIGH  = 2'd3
    } bc_state_e;
endpackage

// File: rtl/i2c_bc_sync.sv
module i2c_bc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, meta_d, stab_q, stab_d;
        always_comb begin
            meta_d = async_i[g];
            stab_d = meta_q;
        end
        // idle bus lines read high
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/i2c_bc_tick.sv
module i2c_bc_tick #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (clr_i || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/i2c_bc_seq.sv
module i2c_bc_seq
    import i2c_bc_pkg::*;
#(
    parameter int SETUP_US    = 1,
    parameter int HALF_US     = 10,
    parameter int PULSE_COUNT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic sda_s_i,
    output logic tick_clr_o,
    output logic active_o,
    output logic scl_pull_o,
    output logic done_o,
    output logic pulsed_o,
    output logic still_low_o
);
    localparam int UMAX = (SETUP_US > HALF_US) ? SETUP_US : HALF_US;
    localparam int UW   = $clog2(UMAX + 1);
    localparam int PW   = $clog2(PULSE_COUNT + 1);
    localparam logic [UW-1:0] SETUP_LAST = UW'(SETUP_US - 1);
    localparam logic [UW-1:0] HALF_LAST  = UW'(HALF_US - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_COUNT - 1);

    typedef struct packed {
        bc_state_e     st;
        logic [UW-1:0] us;
        logic [PW-1:0] pc;
        logic          pend;
        logic          done;
        logic          pulsed;
        logic          still;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            BC_IDLE: begin
                if (start_i || q.pend) begin
                    d.st     = BC_SETUP;
                    d.us     = '0;
                    d.pc     = '0;
                    d.pend   = 1'b0;
                    d.pulsed = 1'b0;
                    d.still  = 1'b0;
                end
            end
            BC_SETUP: begin
                if (tick_i) begin
                    if (q.us == SETUP_LAST) begin
                        d.us = '0;
                        if (!sda_s_i) begin
                            d.pulsed = 1'b1;
                            d.st     = BC_LOW;
                        end else begin
                            d.st   = BC_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
            BC_LOW: begin
                if (tick_i) begin
                    if (q.us == HALF_LAST) begin
                        d.us = '0;
                        d.st = BC_HIGH;
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
            BC_HIGH: begin
                if (tick_i) begin
                    if (q.us == HALF_LAST) begin
                        d.us = '0;
                        if (q.pc == PULSE_LAST) begin
                            d.still = !sda_s_i;
                            d.st    = BC_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.pc = q.pc + 1'b1;
                            d.st = BC_LOW;
                        end
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
            default: d.st = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= BC_IDLE;
            q.us     <= '0;
            q.pc     <= '0;
            q.pend   <= 1'b1;
            q.done   <= 1'b0;
            q.pulsed <= 1'b0;
            q.still  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tick_clr_o  = (q.st == BC_IDLE);
    assign active_o    = (q.st != BC_IDLE);
    assign scl_pull_o  = (q.st == BC_LOW);
    assign done_o      = q.done;
    assign pulsed_o    = q.pulsed;
    assign still_low_o = q.still;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (q.pc < PW'(PULSE_COUNT)));

    // R7
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> done_o);

    // R4
    low_after_pulsed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> pulsed_o);
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
    parameter int CLK_PER_US  = 125,
    parameter int SETUP_US    = 1,
    parameter int HALF_US     = 10,
    parameter int PULSE_COUNT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    input  logic ctrl_scl_oe_i,
    input  logic ctrl_sda_oe_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic ctrl_own_o,
    output logic busy_o,
    output logic done_o,
    output logic pulsed_o,
    output logic still_low_o
);
    logic [1:0] line_s;
    logic       tick, tick_clr, active, scl_pull;

    i2c_bc_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_in_i, sda_in_i}),
        .sync_o  (line_s)
    );

    i2c_bc_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    i2c_bc_seq #(
        .SETUP_US    (SETUP_US),
        .HALF_US     (HALF_US),
        .PULSE_COUNT (PULSE_COUNT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tick_i      (tick),
        .sda_s_i     (line_s[0]),
        .tick_clr_o  (tick_clr),
        .active_o    (active),
        .scl_pull_o  (scl_pull),
        .done_o      (done_o),
        .pulsed_o    (pulsed_o),
        .still_low_o (still_low_o)
    );

    // ownership mux: recovery never pulls SDA
    always_comb begin
        ctrl_own_o = !active;
        busy_o     = active;
        if (active) begin
            scl_oe_o = scl_pull;
            sda_oe_o = 1'b0;
        end else begin
            scl_oe_o = ctrl_scl_oe_i;
            sda_oe_o = ctrl_sda_oe_i;
        end
    end

    // R5
    sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_own_o |-> !sda_oe_o);

    // R9
    pulsed_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulsed_o) |-> busy_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && ctrl_own_o));
endmodule

// File: tb/i2c_bus_clear_test.sv
module i2c_bus_clear_test;
    localparam int CPU = 3;
    localparam int SU  = 1;
    localparam int HU  = 2;
    localparam int NP  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ctrl_scl = 1'b0, ctrl_sda = 1'b0;
    logic scl_oe, sda_oe, own, busy, done, pulsed, still;
    logic scl_in, sda_in;

    int compared = 0;
    int mismatched = 0;
    int hold_left = 0;
    logic prev_scl = 1'b1;
    int cyc = 0;

    always #4 clk = ~clk;

    // bus with pull-ups and a target that keeps SDA low for hold_left SCL rises
    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || (hold_left > 0));

    always @(negedge clk) begin
        if (!prev_scl && scl_in && hold_left > 0) hold_left = hold_left - 1;
        prev_scl = scl_in;
    end

    i2c_bus_clear #(
        .CLK_PER_US(CPU), .SETUP_US(SU), .HALF_US(HU), .PULSE_COUNT(NP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .scl_in_i(scl_in), .sda_in_i(sda_in),
        .ctrl_scl_oe_i(ctrl_scl), .ctrl_sda_oe_i(ctrl_sda),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ctrl_own_o(own),
        .busy_o(busy), .done_o(done), .pulsed_o(pulsed), .still_low_o(still)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            summary();
        end
    end

    // observe one sequence from its first busy cycle until done
    task automatic observe(input int k, input bit poke, input string tag);
        int bcnt = 0, lows = 0, cur = 0, badw = 0, sdab = 0, ctlleak = 0;
        int exp_p = (k > 0) ? NP : 0;
        int exp_b = (SU + ((k > 0) ? 2 * NP * HU : 0)) * CPU;
        while (busy) begin
            bcnt++;
            if (poke && bcnt == 2) begin ctrl_scl = 1'b1; ctrl_sda = 1'b1; end
            if (poke) start = (bcnt == 4);
            if (own) ctlleak++;
            if (sda_oe) sdab++;
            if (scl_oe) cur++;
            else if (cur > 0) begin
                lows++;
                if (cur != HU * CPU) badw++;
                cur = 0;
            end
            if (bcnt > 2000) break;
            @(negedge clk);
        end
        start = 1'b0;
        // R4 R3 pulse count and widths, busy length
        chk(lows == exp_p, {tag, " R4 pulse count"}, lows, exp_p);
        chk(badw == 0, {tag, " R4 low width"}, badw, 0);
        chk(bcnt == exp_b, {tag, " R3/R4 busy length"}, bcnt, exp_b);
        // R5
        chk(sdab == 0, {tag, " R5 sda pulled"}, sdab, 0);
        // R6
        chk(ctlleak == 0, {tag, " R6 own during busy"}, ctlleak, 0);
        // R7 done in first non-busy cycle
        chk(done == 1'b1, {tag, " R7 done pulse"}, int'(done), 1);
        // R9 R10
        chk(pulsed == (k > 0), {tag, " R9 pulsed"}, int'(pulsed), int'(k > 0));
        chk(still == (k > NP), {tag, " R10 still low"}, int'(still), int'(k > NP));
        if (poke) begin
            // R6 controller owns again once idle
            chk(scl_oe == 1'b1 && sda_oe == 1'b1 && own, {tag, " R6 follow ctrl"},
                int'(scl_oe), 1);
        end
        @(negedge clk);
        // R7 R8 single done, no restart from strobe during busy
        chk(!done && !busy, {tag, " R7/R8 single done"}, int'(done | busy), 0);
        ctrl_scl = 1'b0;
        ctrl_sda = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy, {tag, " R8 no restart"}, int'(busy), 0);
    endtask

    initial begin
        // R1 reset state, pins follow controller
        ctrl_scl = 1'b1;
        ctrl_sda = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && own, "R1 reset flags", int'(busy | done), 0);
        chk(scl_oe && sda_oe, "R1 follow ctrl high", int'(scl_oe & sda_oe), 1);
        ctrl_scl = 1'b0;
        ctrl_sda = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 follow ctrl low", int'(scl_oe | sda_oe), 0);
        // R2 automatic run after reset on a free bus
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 auto start", int'(busy), 1);
        observe(0, 1'b0, "startup");
        repeat (10) @(negedge clk);
        chk(!busy, "R2 runs once", int'(busy), 0);
        // sweep target hold length, R3 to R10
        for (int k = 0; k <= NP + 3; k++) begin
            hold_left = k;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
            observe(k, (k == 5 || k == 0), $sformatf("hold%0d", k));
            hold_left = 0;
            repeat (3) @(negedge clk);
        end
        summary();
    end
endmodule